// File: doc/BRIEF.md
# Size-Aware Operand Register File

This block holds the operand registers of a processor core: eight general data registers and eight address registers, the last of which the surrounding core uses as its stack pointer. Every access carries an operand size of byte, word or long word, and the file applies that size on the way in and on the way out. A caller therefore sees only the operand it asked for and never handles the raw 32-bit register when the operation is narrower.

The two register classes merge writes in different ways. A data register takes new bits only in the low-order field that the size selects and keeps its upper bits. An address register always takes a full 32-bit value, so a word operand is sign-extended from bit 15 before it is stored. Byte operands are not defined for address registers. A byte access to an address register, or any access with the reserved size code, raises an error flag and has no effect on the stored state.

The file has two independent combinational read ports and one registered write port. A write becomes visible to the read ports from the cycle after the clock edge that captures it.

Top module: `regfile_sized`

## Requirements
- R1: After reset, every data and address register reads as zero at every legal size.
- R2: A byte write (size code 2'b00) to a data register replaces bits 7:0 and leaves bits 31:8 unchanged.
- R3: A word write (size code 2'b01) to a data register replaces bits 15:0 and leaves bits 31:16 unchanged.
- R4: A long write (size code 2'b10) replaces all 32 bits of a data or address register.
- R5: A word write to an address register stores bits 15:0 of the operand and copies operand bit 15 into bits 31:16.
- R6: A data-register read returns the low 8, 16 or 32 bits for byte, word or long size, with all higher output bits zero.
- R7: An address-register read returns the low 16 bits zero-extended for word size and all 32 bits for long size.
- R8: A byte-size access to an address register raises that port's error flag. A write of this kind changes no register, and a read of this kind returns zero.
- R9: Size code 2'b11 raises that port's error flag on either class. A write with this code changes no register, and a read with it returns zero.
- R10: A read of the register that is being written in the same cycle returns the old value, and the new value appears from the following cycle.
- R11: The two read ports select class, index and size independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd0_idx | input | 3 | Register index for read port 0 |
| rd0_is_addr | input | 1 | Read port 0 class select: 1 for address register, 0 for data register |
| rd0_size | input | 2 | Read port 0 size code: 00 byte, 01 word, 10 long, 11 reserved |
| rd0_data | output | 32 | Read port 0 operand, zero-extended |
| rd0_err | output | 1 | Read port 0 illegal request |
| rd1_idx | input | 3 | Register index for read port 1 |
| rd1_is_addr | input | 1 | Read port 1 class select |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 32 | Read port 1 operand, zero-extended |
| rd1_err | output | 1 | Read port 1 illegal request |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index |
| wr_is_addr | input | 1 | Write class select |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write operand |
| wr_err | output | 1 | Write request illegal; the write is dropped |

## Verification
The hardest case to reach is one where a partial write lands on a register whose upper bits already hold a distinctive value. An unchanged upper field can only be told apart from a cleared or sign-filled one if those bits were non-zero beforehand. The stimulus therefore fills each register with a long pattern whose upper half differs from the register to register, and then writes a word and a byte on top of it. The word operands alternate bit 15 between registers, so the sign extension into an address register is exercised with both polarities. The bench also repeats the illegal requests on registers that already hold data, so that a write which ought to have been dropped would show up on a full long read.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;
  localparam logic [1:0] SZ_RSVD = 2'b11;
endpackage

// File: rtl/rf_reset_sync.sv
module rf_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rf_access_check.sv
module rf_access_check
  import regfile_pkg::*;
(
  input  logic       is_addr,
  input  logic [1:0] size,
  output logic       illegal
);
  always_comb begin
    illegal = 1'b0;
    if (size == SZ_RSVD) illegal = 1'b1;
    if (is_addr && (size == SZ_BYTE)) illegal = 1'b1;
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import regfile_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] reg_val,
  input  logic [1:0]       size,
  input  logic             illegal,
  output logic [WIDTH-1:0] data
);
  always_comb begin
    data = '0;
    if (!illegal) begin
      unique case (size)
        SZ_BYTE: data[7:0]  = reg_val[7:0];
        SZ_WORD: data[15:0] = reg_val[15:0];
        default: data       = reg_val;
      endcase
    end
  end
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge
  import regfile_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] old_val,
  input  logic [WIDTH-1:0] wdata,
  input  logic             is_addr,
  input  logic [1:0]       size,
  output logic [WIDTH-1:0] new_val
);
  localparam int UPPER_W = WIDTH - 16;

  always_comb begin
    new_val = old_val;
    unique case (size)
      SZ_BYTE: new_val[7:0] = wdata[7:0];
      SZ_WORD: begin
        new_val[15:0] = wdata[15:0];
        if (is_addr) new_val[WIDTH-1:16] = {UPPER_W{wdata[15]}};
      end
      default: new_val = wdata;
    endcase
  end
endmodule

// File: rtl/regfile_sized.sv
module regfile_sized
  import regfile_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic             rd0_is_addr,
  input  logic [1:0]       rd0_size,
  output logic [WIDTH-1:0] rd0_data,
  output logic             rd0_err,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic             rd1_is_addr,
  input  logic [1:0]       rd1_size,
  output logic [WIDTH-1:0] rd1_data,
  output logic             rd1_err,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_is_addr,
  input  logic [1:0]       wr_size,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_err
);
  localparam int RD_PORTS = 2;

  logic rst_sync_n;
  logic [NUM_REGS-1:0][WIDTH-1:0] dreg_q, dreg_nxt;
  logic [NUM_REGS-1:0][WIDTH-1:0] areg_q, areg_nxt;
  logic [NUM_REGS-1:0]            dreg_ce, areg_ce;

  rf_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Read ports
  logic [RD_PORTS-1:0][IDX_W-1:0] rp_idx;
  logic [RD_PORTS-1:0]            rp_is_addr;
  logic [RD_PORTS-1:0][1:0]       rp_size;
  logic [RD_PORTS-1:0][WIDTH-1:0] rp_data;
  logic [RD_PORTS-1:0]            rp_err;

  assign rp_idx     = {rd1_idx, rd0_idx};
  assign rp_is_addr = {rd1_is_addr, rd0_is_addr};
  assign rp_size    = {rd1_size, rd0_size};

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [WIDTH-1:0] sel_val;
    assign sel_val = rp_is_addr[p] ? areg_q[rp_idx[p]] : dreg_q[rp_idx[p]];

    rf_access_check u_chk (
      .is_addr (rp_is_addr[p]),
      .size    (rp_size[p]),
      .illegal (rp_err[p])
    );

    rf_read_port #(.WIDTH(WIDTH)) u_port (
      .reg_val (sel_val),
      .size    (rp_size[p]),
      .illegal (rp_err[p]),
      .data    (rp_data[p])
    );
  end

  assign rd0_data = rp_data[0];
  assign rd0_err  = rp_err[0];
  assign rd1_data = rp_data[1];
  assign rd1_err  = rp_err[1];

  // Write port
  logic             wr_illegal;
  logic             wr_ok;
  logic [WIDTH-1:0] wr_old, wr_merged;

  rf_access_check u_wchk (
    .is_addr (wr_is_addr),
    .size    (wr_size),
    .illegal (wr_illegal)
  );

  assign wr_err = wr_en & wr_illegal;
  assign wr_ok  = wr_en & ~wr_illegal;
  assign wr_old = wr_is_addr ? areg_q[wr_idx] : dreg_q[wr_idx];

  rf_write_merge #(.WIDTH(WIDTH)) u_merge (
    .old_val (wr_old),
    .wdata   (wr_data),
    .is_addr (wr_is_addr),
    .size    (wr_size),
    .new_val (wr_merged)
  );

  // Next-state
  always_comb begin
    dreg_ce  = '0;
    areg_ce  = '0;
    dreg_nxt = dreg_q;
    areg_nxt = areg_q;
    if (wr_ok) begin
      if (wr_is_addr) begin
        areg_ce[wr_idx]  = 1'b1;
        areg_nxt[wr_idx] = wr_merged;
      end else begin
        dreg_ce[wr_idx]  = 1'b1;
        dreg_nxt[wr_idx] = wr_merged;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dreg_q <= '0;
      areg_q <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (dreg_ce[i]) dreg_q[i] <= dreg_nxt[i];
        if (areg_ce[i]) areg_q[i] <= areg_nxt[i];
      end
    end
  end

  // Assertions
  AST_DROPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_err |=> (dreg_q == $past(dreg_q)) && (areg_q == $past(areg_q))); // R8

  AST_RSVD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_size == SZ_RSVD) |-> wr_err); // R9

  AST_DATA_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_is_addr && wr_size == SZ_BYTE)
    |=> dreg_q[$past(wr_idx)][WIDTH-1:8] == $past(dreg_q[wr_idx][WIDTH-1:8])); // R2

  AST_ADDR_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_is_addr && wr_size == SZ_WORD)
    |=> areg_q[$past(wr_idx)] == {{(WIDTH-16){$past(wr_data[15])}}, $past(wr_data[15:0])}); // R5

  AST_RD0_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd0_err |-> rd0_data == '0); // R8

  AST_RD1_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd1_err |-> rd1_data == '0); // R9
endmodule

// File: tb/tb_regfile_sized.sv
module tb_regfile_sized;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [2:0]  rd0_idx, rd1_idx, wr_idx;
  logic        rd0_is_addr, rd1_is_addr, wr_is_addr;
  logic [1:0]  rd0_size, rd1_size, wr_size;
  logic [31:0] rd0_data, rd1_data, wr_data;
  logic        rd0_err, rd1_err, wr_err, wr_en;

  int checks = 0;
  int errors = 0;

  logic [31:0] mdr [8];
  logic [31:0] mar [8];

  regfile_sized dut (
    .clk(clk), .rst_n(rst_n),
    .rd0_idx(rd0_idx), .rd0_is_addr(rd0_is_addr), .rd0_size(rd0_size),
    .rd0_data(rd0_data), .rd0_err(rd0_err),
    .rd1_idx(rd1_idx), .rd1_is_addr(rd1_is_addr), .rd1_size(rd1_size),
    .rd1_data(rd1_data), .rd1_err(rd1_err),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_is_addr(wr_is_addr),
    .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic illegal(logic isa, logic [1:0] sz);
    return (sz == 2'b11) || (isa && sz == 2'b00);
  endfunction

  function automatic logic [31:0] exp_rd(logic isa, logic [2:0] idx, logic [1:0] sz);
    logic [31:0] v;
    v = isa ? mar[idx] : mdr[idx];
    if (illegal(isa, sz)) return 32'h0;
    if (sz == 2'b00) return v & 32'h0000_00FF;
    if (sz == 2'b01) return v & 32'h0000_FFFF;
    return v;
  endfunction

  // Port 0 reads (isa, idx, sz); port 1 reads the other class at idx^1 (R11)
  task automatic rd(string tag, logic isa, logic [2:0] idx, logic [1:0] sz);
    @(negedge clk);
    rd0_is_addr = isa;  rd0_idx = idx;        rd0_size = sz;
    rd1_is_addr = !isa; rd1_idx = idx ^ 3'd1; rd1_size = sz;
    #1;
    chk(tag, rd0_data, exp_rd(isa, idx, sz));
    chk(tag, {31'h0, rd0_err}, {31'h0, illegal(isa, sz)});
    chk("R11", rd1_data, exp_rd(!isa, idx ^ 3'd1, sz));
    chk("R11", {31'h0, rd1_err}, {31'h0, illegal(!isa, sz)});
  endtask

  task automatic wr(string tag, logic isa, logic [2:0] idx, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_is_addr = isa; wr_idx = idx; wr_size = sz; wr_data = d;
    #1;
    chk(tag, {31'h0, wr_err}, {31'h0, illegal(isa, sz)});
    @(negedge clk);
    wr_en = 1'b0;
    if (!illegal(isa, sz)) begin
      if (isa) begin
        if (sz == 2'b01) mar[idx] = {{16{d[15]}}, d[15:0]};
        else             mar[idx] = d;
      end else begin
        if (sz == 2'b00)      mdr[idx] = {mdr[idx][31:8], d[7:0]};
        else if (sz == 2'b01) mdr[idx] = {mdr[idx][31:16], d[15:0]};
        else                  mdr[idx] = d;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_is_addr = 1'b0;
    wr_size = 2'b10; wr_data = '0;
    rd0_idx = '0; rd0_is_addr = 1'b0; rd0_size = 2'b10;
    rd1_idx = '0; rd1_is_addr = 1'b0; rd1_size = 2'b10;
    for (int i = 0; i < 8; i++) begin mdr[i] = '0; mar[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: everything zero after reset
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 8; i++)
        rd("R1", c[0], i[2:0], 2'b10);

    // Sweep both classes and all indices
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 8; i++) begin
        logic isa;
        logic [2:0] ix;
        logic [31:0] p, q;
        isa = c[0];
        ix  = i[2:0];
        p = 32'h8000_8000 ^ (i * 32'h1357_9BDF) ^ (isa ? 32'h0F0F_0F0F : 32'h0);
        q = 32'hDEAD_0000 | (i[0] ? 32'h0000_8123 : 32'h0000_7ABC);
        wr("R4", isa, ix, 2'b10, p);
        rd("R4", isa, ix, 2'b10);
        wr(isa ? "R5" : "R3", isa, ix, 2'b01, q);
        rd(isa ? "R5" : "R3", isa, ix, 2'b10);
        wr(isa ? "R8" : "R2", isa, ix, 2'b00, 32'h1234_56C3 ^ i);
        rd(isa ? "R8" : "R2", isa, ix, 2'b10);
        wr("R9", isa, ix, 2'b11, 32'hFFFF_FFFF);
        rd("R9", isa, ix, 2'b10);
        rd(isa ? "R7" : "R6", isa, ix, 2'b01);
        rd(isa ? "R8" : "R6", isa, ix, 2'b00);
        rd("R9", isa, ix, 2'b11);
      end
    end

    // R10: read-during-write returns old value, new one next cycle
    for (int c = 0; c < 2; c++) begin
      logic [31:0] oldv, newv;
      oldv = c[0] ? mar[3] : mdr[3];
      newv = 32'hC0DE_5A5A ^ c;
      @(negedge clk);
      wr_en = 1'b1; wr_is_addr = c[0]; wr_idx = 3'd3; wr_size = 2'b10; wr_data = newv;
      rd0_is_addr = c[0]; rd0_idx = 3'd3; rd0_size = 2'b10;
      #1;
      chk("R10", rd0_data, oldv);
      @(posedge clk);
      #1;
      chk("R10", rd0_data, newv);
      @(negedge clk);
      wr_en = 1'b0;
      if (c[0]) mar[3] = newv; else mdr[3] = newv;
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule